// File: doc/BRIEF.md
# Multi-domain synchronous clock-enable prescaler

This block derives four clock-enable streams from one main clock: one for the processor, one for the high-speed bus, and one for each of two peripheral buses. All four streams come from one shared 8-bit counter that runs freely. Each domain takes its ratio from its own 4-bit field in a 16-bit control word. A field holds a divide-enable bit and a 3-bit select value. With the bit clear, the domain runs at the main rate. With the bit set, the domain runs at the main rate divided by 2^(select+1).

A new control word comes in as one write and takes effect for all four domains together. The update waits until the shared counter next wraps to zero, so every domain starts its new rhythm from the same phase. During the wait a ready flag is low. An optional interrupt pulse marks the moment the new setting takes effect.

Writes made while busy are refused, and so are writes that would leave the domain rates in the wrong order. A separate strobe selects the main clock source, either the oscillator or the PLL. A request for the PLL is honoured only while the PLL reports that it is enabled.

Top module: `clk_presc_top`

## Requirements
- R1: After reset, all four enables are 1 on every cycle, ready is 1, the source indicator shows the oscillator (0), and the interrupt and error pulses are 0.
- R2: Domain d (0 processor, 1 high-speed bus, 2 peripheral A, 3 peripheral B) takes its setting from control bits [4d+3:4d]. Bit 4d+3 is the divide-enable bit and bits [4d+2:4d] are the select value s. With divide-enable set, the domain's enable is 1 exactly on the cycles where the shared counter value is a multiple of 2^(s+1). With divide-enable clear, the enable is 1 on every cycle.
- R3: An accepted control word takes effect for all domains on the first cycle in which the counter reads 0 after the accepting cycle. In that cycle every enable is 1.
- R4: Ready drops to 0 in the cycle after an accepted write. It stays 0 until the counter wraps, and reads 1 in the cycle when the new setting is first in effect.
- R5: If the ready-interrupt enable is 1 at the wrap that applies a setting, the interrupt output pulses for exactly the one cycle in which ready returns to 1. Otherwise it stays 0.
- R6: A control write made while ready is 0 changes no setting. It produces a one-cycle error pulse in the next cycle.
- R7: A control word is refused if the processor would run slower than the high-speed bus, or if the high-speed bus would run slower than either peripheral bus. The active and pending settings stay as they were, ready stays 1, and a one-cycle error pulse follows.
- R8: A domain written with its current field keeps its enable pattern unbroken across the update, while other domains change.
- R9: A source write requesting the PLL switches the source indicator to 1 only if the PLL-enabled input is 1. Otherwise the indicator keeps its value and a one-cycle refusal pulse follows.
- R10: A source write requesting the oscillator always sets the source indicator to 0 in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Main clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_wr | input | 1 | Control word write strobe |
| cfg_wdata | input | 16 | Control word, four 4-bit domain fields |
| rdy_ie | input | 1 | Ready interrupt enable |
| pll_sel_wr | input | 1 | Source select write strobe |
| pll_sel_val | input | 1 | Requested source: 1 PLL, 0 oscillator |
| pll_on | input | 1 | PLL enabled status |
| dom_en | output | 4 | Clock-enable per domain, bit d for domain d |
| cfg_rdy | output | 1 | Setting in effect, no update pending |
| rdy_irq | output | 1 | One-cycle pulse when a new setting becomes effective |
| cfg_err | output | 1 | One-cycle pulse after a refused control write |
| src_is_pll | output | 1 | Main clock source indicator |
| src_refused | output | 1 | One-cycle pulse after a refused PLL request |

## Verification
The assertions check several properties on every cycle. Ready stays low until the counter wraps and comes back right after it. Every enable is high at counter zero. The interrupt fires only on a rising ready. A busy write or an out-of-order write always yields an error pulse. The active setting always respects the rate ordering. The source only moves to the PLL when the PLL was enabled. Two things need the bench's reference model and its directed scenarios: the exact divide pattern of each domain, and the phase continuity of a domain rewritten with the same field.

// File: rtl/clk_presc_pkg.sv
package clk_presc_pkg;
  localparam int DOM_N = 4;
  localparam int SEL_W = 3;
  localparam int FLD_W = SEL_W + 1;
  localparam int CFG_W = DOM_N * FLD_W;
  localparam int CNT_W = 2 ** SEL_W;
  localparam int LOG_W = SEL_W + 1;

  localparam int D_CPU = 0;
  localparam int D_HSB = 1;
  localparam int D_PBA = 2;
  localparam int D_PBB = 3;

  typedef logic [CFG_W-1:0] cfg_t;

  // log2 of the divide ratio for one domain; 0 means undivided
  function automatic logic [LOG_W-1:0] dom_log(input cfg_t c, input int d);
    logic [FLD_W-1:0] f;
    f = c[d*FLD_W +: FLD_W];
    if (f[FLD_W-1]) return {1'b0, f[SEL_W-1:0]} + LOG_W'(1);
    return '0;
  endfunction

  // rates must not increase from processor to bus to peripheral domains
  function automatic logic cfg_legal(input cfg_t c);
    return (dom_log(c, D_CPU) <= dom_log(c, D_HSB)) &&
           (dom_log(c, D_HSB) <= dom_log(c, D_PBA)) &&
           (dom_log(c, D_HSB) <= dom_log(c, D_PBB));
  endfunction
endpackage

// File: rtl/clk_presc_cnt.sv
module clk_presc_cnt #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  output logic [CNT_W-1:0] cnt_q,
  output logic             wrap_evt
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_q + CNT_W'(1);
  end

  // last count before the counter rolls back to zero
  assign wrap_evt = (cnt_q == '1);
endmodule

// File: rtl/clk_presc_ctrl.sv
module clk_presc_ctrl
  import clk_presc_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic cfg_wr,
  input  cfg_t cfg_wdata,
  input  logic rdy_ie,
  input  logic wrap_evt,
  output cfg_t act_cfg,
  output logic cfg_rdy,
  output logic rdy_irq,
  output logic cfg_err,
  output logic cfg_accept,
  output logic cfg_apply
);
  logic busy_q;
  cfg_t pend_q;
  logic irq_q;
  logic err_q;

  assign cfg_accept = cfg_wr && !busy_q && cfg_legal(cfg_wdata);
  assign cfg_apply  = busy_q && wrap_evt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q  <= 1'b0;
      pend_q  <= '0;
      act_cfg <= '0;
      irq_q   <= 1'b0;
      err_q   <= 1'b0;
    end else begin
      irq_q <= cfg_apply && rdy_ie;
      err_q <= cfg_wr && !cfg_accept;
      if (cfg_apply) begin
        act_cfg <= pend_q;
        busy_q  <= 1'b0;
      end else if (cfg_accept) begin
        pend_q <= cfg_wdata;
        busy_q <= 1'b1;
      end
    end
  end

  assign cfg_rdy = !busy_q;
  assign rdy_irq = irq_q;
  assign cfg_err = err_q;
endmodule

// File: rtl/clk_presc_engen.sv
module clk_presc_engen
  import clk_presc_pkg::*;
#(
  parameter int CNT_W_P = CNT_W
) (
  input  logic [CNT_W_P-1:0] cnt_q,
  input  cfg_t               act_cfg,
  output logic [DOM_N-1:0]   dom_en
);
  for (genvar d = 0; d < DOM_N; d++) begin : g_dom
    logic [LOG_W-1:0]   lg;
    logic [CNT_W_P-1:0] msk;
    always_comb begin
      lg        = dom_log(act_cfg, d);
      msk       = (CNT_W_P'(1) << lg) - CNT_W_P'(1);
      dom_en[d] = ((cnt_q & msk) == '0);
    end
  end
endmodule

// File: rtl/clk_presc_src.sv
module clk_presc_src (
  input  logic clk,
  input  logic rst_n,
  input  logic pll_sel_wr,
  input  logic pll_sel_val,
  input  logic pll_on,
  output logic src_is_pll,
  output logic src_refused
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      src_is_pll  <= 1'b0;
      src_refused <= 1'b0;
    end else begin
      src_refused <= pll_sel_wr && pll_sel_val && !pll_on;
      if (pll_sel_wr) begin
        if (!pll_sel_val)  src_is_pll <= 1'b0;
        else if (pll_on)   src_is_pll <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/clk_presc_top.sv
module clk_presc_top
  import clk_presc_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_wr,
  input  logic [CFG_W-1:0] cfg_wdata,
  input  logic             rdy_ie,
  input  logic             pll_sel_wr,
  input  logic             pll_sel_val,
  input  logic             pll_on,
  output logic [DOM_N-1:0] dom_en,
  output logic             cfg_rdy,
  output logic             rdy_irq,
  output logic             cfg_err,
  output logic             src_is_pll,
  output logic             src_refused
);
  logic [CNT_W-1:0] cnt_q;
  logic             wrap_evt;
  cfg_t             act_cfg;
  logic             cfg_accept;
  logic             cfg_apply;

  clk_presc_cnt #(.CNT_W(CNT_W)) cnt_i (
    .clk(clk), .rst_n(rst_n), .cnt_q(cnt_q), .wrap_evt(wrap_evt)
  );

  clk_presc_ctrl ctrl_i (
    .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_wdata(cfg_wdata),
    .rdy_ie(rdy_ie), .wrap_evt(wrap_evt), .act_cfg(act_cfg),
    .cfg_rdy(cfg_rdy), .rdy_irq(rdy_irq), .cfg_err(cfg_err),
    .cfg_accept(cfg_accept), .cfg_apply(cfg_apply)
  );

  clk_presc_engen #(.CNT_W_P(CNT_W)) engen_i (
    .cnt_q(cnt_q), .act_cfg(act_cfg), .dom_en(dom_en)
  );

  clk_presc_src src_i (
    .clk(clk), .rst_n(rst_n), .pll_sel_wr(pll_sel_wr),
    .pll_sel_val(pll_sel_val), .pll_on(pll_on),
    .src_is_pll(src_is_pll), .src_refused(src_refused)
  );
endmodule

// File: rtl/clk_presc_chk.sv
module clk_presc_chk
  import clk_presc_pkg::*;
(
  input logic             clk,
  input logic             rst_n,
  input logic             cfg_wr,
  input logic [CFG_W-1:0] cfg_wdata,
  input logic             cfg_rdy,
  input logic             rdy_irq,
  input logic             cfg_err,
  input logic             wrap_evt,
  input logic [CNT_W-1:0] cnt_q,
  input logic [DOM_N-1:0] dom_en,
  input logic [CFG_W-1:0] act_cfg,
  input logic             src_is_pll,
  input logic             pll_on
);
  a_r3_all_high_at_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q == '0) |-> (&dom_en));

  a_r4_busy_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (!cfg_rdy && !wrap_evt) |=> !cfg_rdy);

  a_r4_ready_after_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    (!cfg_rdy && wrap_evt) |=> cfg_rdy);

  a_r5_irq_on_rise: assert property (@(posedge clk) disable iff (!rst_n)
    rdy_irq |-> $rose(cfg_rdy));

  a_r6_busy_write_err: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_wr && !cfg_rdy) |=> cfg_err);

  a_r7_bad_order_err: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_wr && cfg_rdy && !cfg_legal(cfg_wdata)) |=> (cfg_err && cfg_rdy));

  a_r7_active_ordered: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_legal(act_cfg));

  a_r9_pll_needs_on: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(src_is_pll) |-> $past(pll_on));
endmodule

bind clk_presc_top clk_presc_chk chk_i (
  .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_wdata(cfg_wdata),
  .cfg_rdy(cfg_rdy), .rdy_irq(rdy_irq), .cfg_err(cfg_err),
  .wrap_evt(wrap_evt), .cnt_q(cnt_q), .dom_en(dom_en), .act_cfg(act_cfg),
  .src_is_pll(src_is_pll), .pll_on(pll_on)
);

// File: tb/clk_presc_top_tb_top.sv
module clk_presc_top_tb_top;
  localparam int CLK_P = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cfg_wr = 1'b0;
  logic [15:0] cfg_wdata = '0;
  logic rdy_ie = 1'b0;
  logic pll_sel_wr = 1'b0, pll_sel_val = 1'b0, pll_on = 1'b0;
  logic [3:0] dom_en;
  logic cfg_rdy, rdy_irq, cfg_err, src_is_pll, src_refused;

  int checks = 0;
  int errors = 0;

  // reference model state
  int m_cnt;
  logic [15:0] m_act, m_pend;
  bit m_busy, m_irq, m_err, m_src, m_ref;
  string m_err_tag;
  string phase_tag = "R2";

  always #(CLK_P/2) clk = ~clk;

  clk_presc_top dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_wdata(cfg_wdata),
    .rdy_ie(rdy_ie), .pll_sel_wr(pll_sel_wr), .pll_sel_val(pll_sel_val),
    .pll_on(pll_on), .dom_en(dom_en), .cfg_rdy(cfg_rdy), .rdy_irq(rdy_irq),
    .cfg_err(cfg_err), .src_is_pll(src_is_pll), .src_refused(src_refused)
  );

  // ratio exponent of a domain field: undivided -> 0, else select+1
  function automatic int ratio_exp(input logic [15:0] w, input int d);
    logic [3:0] f;
    f = w >> (4 * d);
    return f[3] ? (int'(f[2:0]) + 1) : 0;
  endfunction

  function automatic logic [3:0] enc_exp(input int e);
    return (e == 0) ? 4'b0000 : {1'b1, 3'(e - 1)};
  endfunction

  function automatic logic [15:0] make_cfg(input int e0, input int e1, input int e2, input int e3);
    return {enc_exp(e3), enc_exp(e2), enc_exp(e1), enc_exp(e0)};
  endfunction

  function automatic bit ordered(input logic [15:0] w);
    int c, h, a, b;
    c = ratio_exp(w, 0); h = ratio_exp(w, 1); a = ratio_exp(w, 2); b = ratio_exp(w, 3);
    return !(c > h || h > a || h > b);
  endfunction

  function automatic logic [3:0] exp_en(input logic [15:0] w, input int cnt);
    logic [3:0] r;
    for (int d = 0; d < 4; d++) r[d] = ((cnt % (1 << ratio_exp(w, d))) == 0);
    return r;
  endfunction

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h t=%0t", tag, act, exp, $time);
    end
  endtask

  // compare outputs, drive this cycle's inputs, advance the model, wait a cycle
  task automatic cyc(input bit wr, input logic [15:0] wd, input bit ie,
                     input bit pw, input bit pv, input bit pon);
    bit acc, rej, wrap;
    chk((m_cnt == 0) ? "R3 enables" : {phase_tag, " enables"}, 16'(dom_en), 16'(exp_en(m_act, m_cnt)));
    chk("R4 ready", 16'(cfg_rdy), 16'(!m_busy));
    chk("R5 irq", 16'(rdy_irq), 16'(m_irq));
    chk({m_err_tag, " err"}, 16'(cfg_err), 16'(m_err));
    chk("R9 src", 16'(src_is_pll), 16'(m_src));
    chk("R9 refused", 16'(src_refused), 16'(m_ref));
    cfg_wr = wr; cfg_wdata = wd; rdy_ie = ie;
    pll_sel_wr = pw; pll_sel_val = pv; pll_on = pon;
    acc  = wr && !m_busy && ordered(wd);
    rej  = wr && !acc;
    wrap = (m_cnt == 255);
    m_irq = m_busy && wrap && ie;
    m_err = rej;
    if (rej) m_err_tag = m_busy ? "R6" : "R7";
    if (m_busy && wrap) begin m_act = m_pend; m_busy = 0; end
    else if (acc) begin m_pend = wd; m_busy = 1; end
    m_ref = pw && pv && !pon;
    if (pw) begin
      if (!pv) m_src = 0;
      else if (pon) m_src = 1;
    end
    m_cnt = (m_cnt + 1) % 256;
    @(negedge clk);
  endtask

  task automatic idle(input int n, input bit ie, input bit pon);
    for (int i = 0; i < n; i++) cyc(0, 16'h0, ie, 0, 0, pon);
  endtask

  task automatic finish_run();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    #(CLK_P * 150000);
    errors++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    logic [15:0] w;
    void'($urandom(32'd7171));
    m_cnt = 0; m_act = '0; m_pend = '0; m_busy = 0; m_irq = 0; m_err = 0;
    m_src = 0; m_ref = 0; m_err_tag = "R6";
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1: reset state
    chk("R1 enables", 16'(dom_en), 16'hF);
    chk("R1 ready", 16'(cfg_rdy), 16'h1);
    chk("R1 src", 16'(src_is_pll), 16'h0);
    chk("R1 pulses", 16'({rdy_irq, cfg_err, src_refused}), 16'h0);
    idle(20, 0, 0);

    // R2/R3/R4/R5: divided setting with interrupt
    cyc(1, make_cfg(1, 2, 3, 4), 1, 0, 0, 0);
    // R6: write while pending
    cyc(1, make_cfg(0, 0, 0, 0), 1, 0, 0, 0);
    idle(300, 1, 0);
    // R7: processor slower than bus
    cyc(1, make_cfg(3, 1, 4, 4), 0, 0, 0, 0);
    idle(10, 0, 0);
    // R7: bus slower than peripheral B
    cyc(1, make_cfg(1, 5, 6, 4), 0, 0, 0, 0);
    idle(10, 0, 0);
    // R8: processor field rewritten unchanged, others change; no interrupt
    phase_tag = "R8";
    cyc(1, make_cfg(1, 3, 8, 5), 0, 0, 0, 0);
    idle(520, 0, 0);
    phase_tag = "R2";
    // highest ratio on all domains
    cyc(1, make_cfg(8, 8, 8, 8), 1, 0, 0, 0);
    idle(600, 1, 0);

    // R9: PLL request refused while off, then accepted
    cyc(0, 16'h0, 0, 1, 1, 0);
    idle(3, 0, 0);
    cyc(0, 16'h0, 0, 1, 1, 1);
    idle(3, 0, 1);
    chk("R9 src after grant", 16'(src_is_pll), 16'h1);
    // R10: back to oscillator even with PLL enabled
    cyc(0, 16'h0, 0, 1, 0, 1);
    idle(2, 0, 1);
    chk("R10 src oscillator", 16'(src_is_pll), 16'h0);

    // random phase
    for (int i = 0; i < 9000; i++) begin
      bit wr, pw;
      int e0, e1, e2, e3;
      wr = ($urandom % 40) == 0;
      pw = ($urandom % 30) == 0;
      e0 = $urandom % 9;
      e1 = e0 + ($urandom % (9 - e0));
      e2 = e1 + ($urandom % (9 - e1));
      e3 = e1 + ($urandom % (9 - e1));
      w = make_cfg(e0, e1, e2, e3);
      if (($urandom % 5) == 0) w = make_cfg(8, $urandom % 8, 8, 8);
      cyc(wr, w, 1'($urandom), pw, 1'($urandom), 1'($urandom));
    end
    idle(300, 0, 0);
    finish_run();
  end
endmodule